// File: doc/BRIEF.md
# Video-Contention Wait-State Generator

This block counts processor clock cycles (T-states) across a video frame. It tells the CPU how many extra wait cycles to add when it touches RAM that the display fetcher also reads. A frame is 311 lines of 228 T-states each. At the first T-state of every frame the block raises a frame-interrupt pulse that lasts a fixed number of cycles. While the display is being fetched, a memory request to a contended bank is answered with a wait count between 0 and 7. That count follows a repeating eight-slot pattern.

Two machine variants are supported. They differ in three things: the T-state at which fetching starts, the shape of the eight-slot pattern, and which RAM banks the fetcher shares. The window at 0x4000–0x7FFF always holds the screen bank. The window at 0xC000–0xFFFF holds whichever bank the memory mapper reports. The wait count is combinational from the registered frame position and the current request, so the CPU can sample it in the same cycle as its strobe. Both variants' fetch positions are tracked at all times, so changing the variant select takes effect at once.

Top module: `contention_wait_gen`

## Requirements
- R1: The T-state counter runs 0 to 70907 and then wraps to 0, giving a 70908-cycle frame (228 × 311). `frame_int` is high during the first 32 T-states of every frame (T-states 0 to 31) and low otherwise.
- R2: With `late_variant`=0, a fetch slot is open from T-state 14361 + 228·n (n = 0..191). At column c of the open slot (c = 0..127), the wait is 6,5,4,3,2,1,0,0 indexed by c mod 8.
- R3: With `late_variant`=1, the slot opens from T-state 14365 + 228·n. The wait is 1,0,7,6,5,4,3,2 indexed by c mod 8.
- R4: Within each line, only columns 0..127 after the slot start can produce a nonzero wait. The remaining 100 columns of the line always give 0.
- R5: Only the 192 active lines produce waits. Before the first active line and from the 193rd line onward the wait is 0, and this repeats in every frame.
- R6: Address bits [15:14] select the window. Value 01 (0x4000–0x7FFF) is always contended. Values 00 (0x0000–0x3FFF) and 10 (0x8000–0xBFFF) are never contended.
- R7: For value 11 (0xC000–0xFFFF), `hi_bank` decides contention. In the early variant banks 1, 3, 5 and 7 are contended. In the late variant banks 4, 5, 6 and 7 are contended.
- R8: With `mem_req` low, `wait_cycles` is 0.
- R9: Synchronous active-low reset returns the counter to T-state 0 and closes all fetch slots. While reset is held, `frame_int` is 1 and `wait_cycles` is 0. The cycle reset is released is T-state 0.
- R10: A change of `late_variant` alters `wait_cycles` in the same cycle, with no restart of the frame count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock, one T-state per cycle |
| rst_n | input | 1 | Synchronous active-low reset, realigns the frame |
| mem_req | input | 1 | CPU memory access strobe |
| mem_addr | input | 16 | Address of the access |
| hi_bank | input | 3 | RAM bank currently mapped at 0xC000 |
| late_variant | input | 1 | 0 selects the early machine, 1 the late machine |
| frame_int | output | 1 | Frame interrupt, high for the first 32 T-states |
| wait_cycles | output | 3 | Extra wait cycles for the current access |

## Verification
The bench builds the block with its default parameters. These are the real 228-cycle line, 311-line frame, 192 active lines, 128-cycle fetch window and both true start offsets. With these values the first and last active lines, the column-128 cut-off, the frame wrap at 70908 and the first fetch of the second frame can all be reached within one run. The stimulus table steps through ascending T-states and switches variant, window and bank at points where the two patterns give different values. Directed tests then apply reset in the middle of an open slot and flip the variant select within a single cycle.

// File: rtl/contention_pkg.sv
// contention_pkg: shared types and the per-variant slot delay pattern.
// Assumes the fetch window is a multiple of 8 columns, so the pattern
// index is simply the low three bits of the column counter.
package contention_pkg;

    typedef enum logic {
        VARIANT_EARLY = 1'b0,
        VARIANT_LATE  = 1'b1
    } variant_e;

    // Wait count for the slot phase ph (column mod 8) of the given variant.
    function automatic logic [2:0] slot_delay(input variant_e v, input logic [2:0] ph);
        logic [2:0] d;
        if (v == VARIANT_EARLY) begin
            d = (ph < 3'd6) ? 3'(3'd6 - ph) : 3'd0;
        end else begin
            case (ph)
                3'd0:    d = 3'd1;
                3'd1:    d = 3'd0;
                default: d = 3'(4'd9 - 4'(ph));
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/cw_frame_timer.sv
// cw_frame_timer: free-running T-state counter over one video frame and the
// registered frame-interrupt pulse. Assumes one clk cycle per T-state and
// a synchronous active-low reset that realigns the counter to T-state 0.
module cw_frame_timer #(
    parameter int LINE_T      = 228,
    parameter int FRAME_LINES = 311,
    parameter int INT_LEN     = 32,
    parameter int TW          = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [TW-1:0] tstate,
    output logic          frame_int
);
    localparam int FRAME_T = LINE_T * FRAME_LINES;
    localparam logic [TW-1:0] LAST_T  = TW'(FRAME_T - 1);
    localparam logic [TW-1:0] INT_END = TW'(INT_LEN);

    logic [TW-1:0] t_next;

    // Next T-state with wrap at the end of the frame.
    always_comb begin
        t_next = (tstate == LAST_T) ? '0 : tstate + 1'b1;
    end

    // Advance the counter and register the interrupt window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tstate    <= '0;
            frame_int <= 1'b1;
        end else begin
            tstate    <= t_next;
            frame_int <= (t_next < INT_END);
        end
    end

    assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tstate == LAST_T) |=> (tstate == '0));
    assert_int_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_int) |-> (tstate == '0));
    assert_int_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_int) |-> (tstate == INT_END));
    assert_reset_R9: assert property (@(posedge clk)
        !rst_n |=> (tstate == '0) && frame_int);

endmodule

// File: rtl/cw_slot_tracker.sv
// cw_slot_tracker: follows the display fetch for one variant. It arms one
// cycle before START, then steps a column counter over each line and a
// line counter over the active lines. Assumes START plus the active area
// ends before the frame wraps.
module cw_slot_tracker #(
    parameter int START        = 14361,
    parameter int LINE_T       = 228,
    parameter int ACTIVE_LINES = 192,
    parameter int WINDOW       = 128,
    parameter int TW           = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] tstate,
    output logic          slot_open,
    output logic [2:0]    phase
);
    localparam int CW = $clog2(LINE_T);
    localparam int LW = $clog2(ACTIVE_LINES);
    localparam logic [TW-1:0] ARM_T    = TW'(START - 1);
    localparam logic [CW-1:0] COL_LAST = CW'(LINE_T - 1);
    localparam logic [CW-1:0] COL_WIN  = CW'(WINDOW);
    localparam logic [LW-1:0] LN_LAST  = LW'(ACTIVE_LINES - 1);

    logic          active;
    logic [CW-1:0] col;
    logic [LW-1:0] line;

    // Step the column and line position of the fetch area.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            col    <= '0;
            line   <= '0;
        end else if (tstate == ARM_T) begin
            active <= 1'b1;
            col    <= '0;
            line   <= '0;
        end else if (active) begin
            if (col == COL_LAST) begin
                col <= '0;
                if (line == LN_LAST) active <= 1'b0;
                else                 line   <= line + 1'b1;
            end else begin
                col <= col + 1'b1;
            end
        end
    end

    // Only the first WINDOW columns of each line fetch video data.
    always_comb begin
        slot_open = active && (col < COL_WIN);
        phase     = col[2:0];
    end

    assert_col_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (col <= COL_LAST));
    assert_line_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (line <= LN_LAST));
    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> (col == '0) && (line == '0) && ($past(tstate) == ARM_T));

endmodule

// File: rtl/cw_bank_decode.sv
// cw_bank_decode: decides whether an address lands in RAM that the video
// fetcher shares. The 0x4000 window always holds SCREEN_BANK. The 0xC000
// window holds hi_bank. Each variant has its own contended-bank mask.
module cw_bank_decode #(
    parameter logic [7:0] EARLY_MASK  = 8'b1010_1010,
    parameter logic [7:0] LATE_MASK   = 8'b1111_0000,
    parameter int         SCREEN_BANK = 5
) (
    input  logic [1:0] region,
    input  logic [2:0] hi_bank,
    input  logic       late,
    output logic       contended
);
    logic [7:0] mask;

    // Pick the mask of the selected variant and look up the window's bank.
    always_comb begin
        mask = late ? LATE_MASK : EARLY_MASK;
        case (region)
            2'b01:   contended = mask[SCREEN_BANK];
            2'b11:   contended = mask[hi_bank];
            default: contended = 1'b0;
        endcase
    end

endmodule

// File: rtl/contention_wait_gen.sv
// contention_wait_gen: top of the wait-state generator. One frame timer
// drives one slot tracker per variant (built by generate). The variant
// select muxes the tracker, the delay pattern and the bank mask, all
// combinationally. Assumes late_variant is static in normal use, but a
// change to it is honoured in the same cycle.
module contention_wait_gen #(
    parameter int LINE_T       = 228,
    parameter int FRAME_LINES  = 311,
    parameter int ACTIVE_LINES = 192,
    parameter int WINDOW       = 128,
    parameter int INT_LEN      = 32,
    parameter int EARLY_START  = 14361,
    parameter int LATE_START   = 14365
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mem_req,
    input  logic [15:0] mem_addr,
    input  logic [2:0]  hi_bank,
    input  logic        late_variant,
    output logic        frame_int,
    output logic [2:0]  wait_cycles
);
    import contention_pkg::*;

    localparam int TW = $clog2(LINE_T * FRAME_LINES);

    logic [TW-1:0] tstate;
    logic [1:0]    open_v;
    logic [2:0]    phase_v [2];
    logic          contended;
    variant_e      var_sel;

    cw_frame_timer #(
        .LINE_T(LINE_T), .FRAME_LINES(FRAME_LINES), .INT_LEN(INT_LEN), .TW(TW)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .tstate(tstate), .frame_int(frame_int)
    );

    for (genvar v = 0; v < 2; v++) begin : g_track
        localparam int START_V = (v == 0) ? EARLY_START : LATE_START;
        cw_slot_tracker #(
            .START(START_V), .LINE_T(LINE_T), .ACTIVE_LINES(ACTIVE_LINES),
            .WINDOW(WINDOW), .TW(TW)
        ) u_track (
            .clk(clk), .rst_n(rst_n), .tstate(tstate),
            .slot_open(open_v[v]), .phase(phase_v[v])
        );
    end

    cw_bank_decode u_bank (
        .region(mem_addr[15:14]), .hi_bank(hi_bank),
        .late(late_variant), .contended(contended)
    );

    // Combine request, contention and the selected variant's slot delay.
    always_comb begin
        var_sel = variant_e'(late_variant);
        if (mem_req && contended && open_v[late_variant])
            wait_cycles = slot_delay(var_sel, phase_v[late_variant]);
        else
            wait_cycles = 3'd0;
    end

    assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_req |-> (wait_cycles == 3'd0));
    assert_uncontended_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr[15:14] == 2'b00 || mem_addr[15:14] == 2'b10) |-> (wait_cycles == 3'd0));
    assert_even_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!late_variant && mem_addr[15:14] == 2'b11 && !hi_bank[0]) |-> (wait_cycles == 3'd0));
    assert_low_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (late_variant && mem_addr[15:14] == 2'b11 && !hi_bank[2]) |-> (wait_cycles == 3'd0));
    assert_int_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_int |-> (wait_cycles == 3'd0));

endmodule

// File: tb/sim_contention_wait_gen.sv
module sim_contention_wait_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req = 1'b0;
    logic [15:0] mem_addr = 16'h0000;
    logic [2:0]  hi_bank = 3'd0;
    logic        late_variant = 1'b0;
    logic        frame_int;
    logic [2:0]  wait_cycles;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    contention_wait_gen u0 (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
        .hi_bank(hi_bank), .late_variant(late_variant),
        .frame_int(frame_int), .wait_cycles(wait_cycles)
    );

    // Vector table: T-state since release, variant, addr[15:14], hi bank,
    // request, expected wait, expected interrupt, requirement tag.
    localparam int N = 40;
    localparam int VT [N] = '{0,31,32,100,14360,14361,14362,14365,14366,14367,
        14368,14369,14370,14371,14372,14373,14374,14375,14376,14377,
        14378,14379,14380,14381,14382,14485,14489,14492,14493,14589,
        14593,57909,57913,58034,58137,70907,70908,70939,70940,85269};
    localparam int VV [N] = '{0,0,0,0,0,0,1,1,1,1, 0,0,0,0,1,1,1,1,1,1,
        0,1,0,1,0,0,0,1,1,0, 1,0,1,0,0,0,0,0,0,0};
    localparam int VR [N] = '{1,1,1,1,1,1,1,1,1,1, 1,1,3,3,3,3,2,0,1,1,
        3,3,3,3,2,1,1,1,1,1, 1,1,1,1,1,1,1,1,1,1};
    localparam int VB [N] = '{0,0,0,0,0,0,0,0,0,0, 0,0,3,4,4,3,0,0,0,0,
        5,7,6,1,0,0,0,0,0,0, 0,0,0,0,0,0,0,0,0,0};
    localparam int VQ [N] = '{1,1,1,1,1,1,1,1,1,1, 1,1,1,1,1,1,1,1,0,1,
        1,1,1,1,1,1,1,1,1,1, 1,1,1,1,1,1,1,1,1,1};
    localparam int VW [N] = '{0,0,0,0,0,6,0,1,0,7, 0,6,5,0,2,0,0,0,0,5,
        5,3,0,0,0,2,0,2,0,6, 1,6,1,1,0,0,0,0,0,6};
    localparam int VI [N] = '{1,1,0,0,0,0,0,0,0,0, 0,0,0,0,0,0,0,0,0,0,
        0,0,0,0,0,0,0,0,0,0, 0,0,0,0,0,0,1,1,0,0};
    // Tags: R9 reset T0, R1 interrupt edges, R5 before area, R2 early start,
    // R3 late start, R10 mixed, R7 high window banks, R6 other windows,
    // R8 no request, R4 column-128 cut-off, R5 last line, R1 wrap.
    localparam int VT_REQ [N] = '{9,1,1,5,5,2,3,3,3,3, 2,2,7,7,7,7,6,6,8,3,
        7,7,7,7,6,2,4,3,4,2, 3,5,5,2,5,1,1,1,1,1};

    task automatic check(input string tag, input int got, input int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s at T=%0d: got %0d expected %0d", tag, cyc, got, exp);
        end
    endtask

    // Advance to the negedge where the design's counter equals t.
    task automatic go_to(input int t);
        repeat (t - cyc) @(negedge clk);
        cyc = t;
    endtask

    task automatic drive(input int v, input int r, input int b, input int q);
        late_variant = v[0];
        mem_addr     = {r[1:0], 14'h0123};
        hi_bank      = b[2:0];
        mem_req      = q[0];
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: held in reset, interrupt high and no wait.
        drive(0, 1, 0, 1);
        #1;
        check("R9 reset int", int'(frame_int), 1);
        check("R9 reset wait", int'(wait_cycles), 0);
        rst_n = 1'b1;
        cyc = 0;

        for (int i = 0; i < N; i++) begin
            go_to(VT[i]);
            drive(VV[i], VR[i], VB[i], VQ[i]);
            #1;
            check($sformatf("R%0d wait", VT_REQ[i]), int'(wait_cycles), VW[i]);
            check($sformatf("R%0d int", VT_REQ[i]), int'(frame_int), VI[i]);
        end

        // R9: reset in the middle of an open early slot (col 40 -> 6).
        go_to(85309);
        drive(0, 1, 0, 1);
        #1;
        check("R2 mid slot", int'(wait_cycles), 6);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        check("R9 slot closed", int'(wait_cycles), 0);
        check("R9 counter T0", int'(frame_int), 1);
        rst_n = 1'b1;
        cyc = 0;
        go_to(14360);
        #1;
        check("R9 realigned early", int'(wait_cycles), 0);
        go_to(14361);
        #1;
        check("R9 realigned start", int'(wait_cycles), 6);

        // R10: same cycle, flip the variant (early col4 -> 2, late col0 -> 1).
        go_to(14365);
        drive(0, 1, 0, 1);
        #1;
        check("R10 early view", int'(wait_cycles), 2);
        late_variant = 1'b1;
        #1;
        check("R10 late view", int'(wait_cycles), 1);
        drive(1, 1, 0, 0);
        #1;
        check("R8 idle", int'(wait_cycles), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule